// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block runs the control side of taking and leaving an exception in a small 16-bit processor whose program address is 23 bits wide. The low 16 bits come from the PC and the upper 7 bits come from a program bank held here.

On entry it does four things. It keeps a return address, which is the current PC minus 2. It keeps the status word and the current program bank. It hands the datapath a status word with both interrupt enables cleared. It then reads the handler address from a vector table through a single-outstanding valid/ready read port. When the read data arrives, the new PC goes to the datapath, the program bank is zeroed and instruction fetch restarts.

A return operation puts the saved PC, status word and bank back. A small set of special operations lets software read and write the following:
- the saved PC;
- the vector base;
- a packed word that holds the saved bank and the current bank.

A trap operation enters through the same path with a software-chosen exception number. An unknown operation code also enters through that path, using a fixed invalid-operation number.

The PC, the status word and the register file belong to the surrounding datapath. This block only issues one-cycle load strobes to it. Every strobe and read result appears in the cycle after the edge that samples the request.

Top module: `exc_sequencer`

## Requirements
- R1: On entry the saved return address becomes the sampled `cur_pc` minus 2, modulo 2^16. It is readable through operation code 4.
- R2: On entry the sampled `cur_sr` and the current bank are saved. The saved bank is read back in bits 14:8 of the packed word (code 2). The saved status word is given back by a return (code 0).
- R3: One cycle after an accepted entry, `sr_load_valid` is high and `sr_load_value` equals `cur_sr` with bit 0 and bit 1, the two interrupt enables, cleared.
- R4: The vector read address is (vector base + 2 × exception number) modulo 2^16. `vrd_valid` and `vrd_addr` stay steady until `vrd_ready` is seen, and at most one read is outstanding.
- R5: The cycle after read data is accepted, the following hold:
  - `pc_load_valid` is high and `pc_load_value` equals the data;
  - `fetch_restart` pulses;
  - the current bank is 0;
  - `busy` falls.
- R6: A return (code 0) pulses `pc_load_valid` with the saved PC and `sr_load_valid` with the saved status word. It also sets the current bank to the saved bank and pulses `fetch_restart`.
- R7: Code 2 returns, with `sop_rvalid`, a word whose bits 14:8 hold the saved bank and bits 6:0 the current bank. Bits 15 and 7 are 0.
- R8: Code 3 loads the saved bank from bits 14:8 and the current bank from bits 6:0 of `sop_wdata`, and pulses `fetch_restart`.
- R9: Code 5 writes the saved PC and code 7 writes the vector base. Code 4 and code 6 read them back.
- R10: Code 1 enters with exception number `sop_wdata[NUM_W-1:0]`. Codes 8 to 15 enter with number `BAD_OP_NUM` (default 1).
- R11: `busy` is high from the cycle after an accepted entry until the fetch restart. While `busy` is high, `exc_req` and `sop_valid` are ignored. When `busy` is low and both are high together, `exc_req` wins and the operation is dropped.
- R12: After reset the following hold:
  - `busy`, all strobes and `vrd_valid` are 0;
  - the bank, saved PC and vector base read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception entry request |
| exc_num | input | NUM_W | Exception number for `exc_req` |
| cur_pc | input | 16 | Current low PC from the datapath |
| cur_sr | input | 16 | Current status word from the datapath |
| sop_valid | input | 1 | Special operation request |
| sop_code | input | 4 | Special operation code |
| sop_wdata | input | 16 | Operand of the special operation |
| vrd_valid | output | 1 | Vector read request valid |
| vrd_addr | output | 16 | Vector read address |
| vrd_ready | input | 1 | Vector read request accepted |
| vrd_rvalid | input | 1 | Vector read data valid |
| vrd_rdata | input | 16 | Vector read data |
| busy | output | 1 | Entry sequence in progress |
| pc_bank | output | 7 | Current program bank (address bits 22:16) |
| pc_load_valid | output | 1 | PC load strobe |
| pc_load_value | output | 16 | PC value to load |
| sr_load_valid | output | 1 | Status word load strobe |
| sr_load_value | output | 16 | Status word value to load |
| fetch_restart | output | 1 | Restart instruction fetch |
| sop_rvalid | output | 1 | Special read result valid |
| sop_rdata | output | 16 | Special read result |

## Verification
The assertions take for granted that read data never comes back unless the request has already been accepted. They also assume it comes back exactly once per request, so that a data beat cannot arrive in the same cycle as the handshake or while the block is idle. The bench memory model respects this. It raises `vrd_ready` for one cycle, then drives `vrd_rvalid` for one cycle in a later cycle, and otherwise holds both low. All inputs change on the falling edge, so the request-stability and busy-quiet properties see only clean, edge-sampled stimulus.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned BANK_W  = 7;
    localparam int unsigned OPC_W   = 4;
    localparam int unsigned HALF_W  = WORD_W / 2;
    localparam int unsigned IE0_BIT = 0;
    localparam int unsigned IE1_BIT = 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BANK_W-1:0] bank_t;

    // special operation codes; values above OP_VBASE_WR are undefined
    typedef enum logic [OPC_W-1:0] {
        OP_RETURN   = 4'd0,
        OP_TRAP     = 4'd1,
        OP_BANK_RD  = 4'd2,
        OP_BANK_WR  = 4'd3,
        OP_EPC_RD   = 4'd4,
        OP_EPC_WR   = 4'd5,
        OP_VBASE_RD = 4'd6,
        OP_VBASE_WR = 4'd7
    } sop_e;

    typedef enum logic [1:0] {
        VF_IDLE = 2'd0,
        VF_REQ  = 2'd1,
        VF_WAIT = 2'd2
    } vf_state_e;

    typedef struct packed {
        logic  valid;
        word_t value;
    } word_strobe_t;

    function automatic word_t vector_addr(word_t base, word_t num);
        return base + word_t'(num << 1);
    endfunction

    function automatic word_t clear_int_enables(word_t sr);
        word_t m;
        m = '1;
        m[IE0_BIT] = 1'b0;
        m[IE1_BIT] = 1'b0;
        return sr & m;
    endfunction

    function automatic word_t pack_banks(bank_t saved, bank_t cur);
        word_t w;
        w = '0;
        w[HALF_W +: BANK_W] = saved;
        w[0 +: BANK_W]      = cur;
        return w;
    endfunction

    function automatic bank_t saved_field(word_t w);
        return w[HALF_W +: BANK_W];
    endfunction

    function automatic bank_t cur_field(word_t w);
        return w[0 +: BANK_W];
    endfunction
endpackage

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
    import exc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t start_addr,
    output logic  rd_valid,
    output word_t rd_addr,
    input  logic  rd_ready,
    input  logic  rd_rvalid,
    input  word_t rd_rdata,
    output logic  done,
    output word_t done_data,
    output logic  active
);
    vf_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= VF_IDLE;
            rd_addr <= '0;
        end else begin
            unique case (state)
                VF_IDLE: if (start) begin
                    state   <= VF_REQ;
                    rd_addr <= start_addr;
                end
                VF_REQ:  if (rd_ready)  state <= VF_WAIT;
                VF_WAIT: if (rd_rvalid) state <= VF_IDLE;
                default: state <= VF_IDLE;
            endcase
        end
    end

    assign rd_valid  = (state == VF_REQ);
    assign done      = (state == VF_WAIT) && rd_rvalid;
    assign done_data = rd_rdata;
    assign active    = (state != VF_IDLE);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R4
    AST_ADDR_LATCHED: assert property (@(posedge clk) disable iff (rst)
        start && !active |=> rd_valid && rd_addr == $past(start_addr)); // R4
    AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (rst)
        rd_rvalid |-> state == VF_WAIT); // R4
endmodule

// File: rtl/exc_ctx_regs.sv
module exc_ctx_regs
    import exc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  save_en,
    input  word_t save_pc,
    input  word_t save_sr,
    input  logic  bank_clear,
    input  logic  bank_restore,
    input  logic  bank_write,
    input  logic  epc_write,
    input  logic  vbase_write,
    input  word_t wr_value,
    output word_t epc,
    output word_t esr,
    output word_t vbase,
    output bank_t cur_bank,
    output bank_t saved_bank
);
    localparam word_t RET_ADJ = word_t'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            epc        <= '0;
            esr        <= '0;
            vbase      <= '0;
            cur_bank   <= '0;
            saved_bank <= '0;
        end else begin
            if (save_en) begin
                epc        <= save_pc - RET_ADJ;
                esr        <= save_sr;
                saved_bank <= cur_bank;
            end
            if (bank_clear)        cur_bank <= '0;
            else if (bank_restore) cur_bank <= saved_bank;
            else if (bank_write)   cur_bank <= cur_field(wr_value);
            if (bank_write)  saved_bank <= saved_field(wr_value);
            if (epc_write)   epc        <= wr_value;
            if (vbase_write) vbase      <= wr_value;
        end
    end

    AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({save_en, bank_clear, bank_restore, bank_write, epc_write, vbase_write})); // R11
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
    import exc_pkg::*;
#(
    parameter int unsigned      NUM_W      = 8,
    parameter logic [NUM_W-1:0] BAD_OP_NUM = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exc_req,
    input  logic [NUM_W-1:0] exc_num,
    input  logic [15:0]      cur_pc,
    input  logic [15:0]      cur_sr,
    input  logic             sop_valid,
    input  logic [3:0]       sop_code,
    input  logic [15:0]      sop_wdata,
    output logic             vrd_valid,
    output logic [15:0]      vrd_addr,
    input  logic             vrd_ready,
    input  logic             vrd_rvalid,
    input  logic [15:0]      vrd_rdata,
    output logic             busy,
    output logic [6:0]       pc_bank,
    output logic             pc_load_valid,
    output logic [15:0]      pc_load_value,
    output logic             sr_load_valid,
    output logic [15:0]      sr_load_value,
    output logic             fetch_restart,
    output logic             sop_rvalid,
    output logic [15:0]      sop_rdata
);
    logic             active, vf_done;
    word_t            vf_data;
    word_t            epc, esr, vbase;
    bank_t            cur_bank, saved_bank;

    logic             take_exc, op_go, entry_go;
    logic [NUM_W-1:0] entry_num;
    logic             do_return, do_bank_wr, do_epc_wr, do_vbase_wr;
    logic             rd_go;
    word_t            rd_value;

    word_strobe_t     pc_q, sr_q, rd_q;
    logic             restart_q;

    // request arbitration: entry beats a special operation, both dropped while busy (R11)
    assign take_exc = !active && exc_req;
    assign op_go    = !active && !exc_req && sop_valid;

    always_comb begin
        entry_go    = take_exc;
        entry_num   = exc_num;
        do_return   = 1'b0;
        do_bank_wr  = 1'b0;
        do_epc_wr   = 1'b0;
        do_vbase_wr = 1'b0;
        rd_go       = 1'b0;
        rd_value    = '0;
        if (op_go) begin
            case (sop_code)
                OP_RETURN:   do_return = 1'b1;
                OP_TRAP: begin
                    entry_go  = 1'b1;
                    entry_num = sop_wdata[NUM_W-1:0];
                end
                OP_BANK_RD: begin
                    rd_go    = 1'b1;
                    rd_value = pack_banks(saved_bank, cur_bank);
                end
                OP_BANK_WR:  do_bank_wr = 1'b1;
                OP_EPC_RD: begin
                    rd_go    = 1'b1;
                    rd_value = epc;
                end
                OP_EPC_WR:   do_epc_wr = 1'b1;
                OP_VBASE_RD: begin
                    rd_go    = 1'b1;
                    rd_value = vbase;
                end
                OP_VBASE_WR: do_vbase_wr = 1'b1;
                default: begin
                    entry_go  = 1'b1;
                    entry_num = BAD_OP_NUM;
                end
            endcase
        end
    end

    exc_vec_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (entry_go),
        .start_addr (vector_addr(vbase, word_t'(entry_num))),
        .rd_valid   (vrd_valid),
        .rd_addr    (vrd_addr),
        .rd_ready   (vrd_ready),
        .rd_rvalid  (vrd_rvalid),
        .rd_rdata   (vrd_rdata),
        .done       (vf_done),
        .done_data  (vf_data),
        .active     (active)
    );

    exc_ctx_regs u_ctx (
        .clk          (clk),
        .rst          (rst),
        .save_en      (entry_go),
        .save_pc      (cur_pc),
        .save_sr      (cur_sr),
        .bank_clear   (vf_done),
        .bank_restore (do_return),
        .bank_write   (do_bank_wr),
        .epc_write    (do_epc_wr),
        .vbase_write  (do_vbase_wr),
        .wr_value     (sop_wdata),
        .epc          (epc),
        .esr          (esr),
        .vbase        (vbase),
        .cur_bank     (cur_bank),
        .saved_bank   (saved_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            sr_q      <= '0;
            rd_q      <= '0;
            restart_q <= 1'b0;
        end else begin
            pc_q.valid <= 1'b0;
            sr_q.valid <= 1'b0;
            rd_q.valid <= 1'b0;
            restart_q  <= 1'b0;
            if (entry_go) begin
                sr_q.valid <= 1'b1;
                sr_q.value <= clear_int_enables(cur_sr);
            end
            if (do_return) begin
                pc_q.valid <= 1'b1;
                pc_q.value <= epc;
                sr_q.valid <= 1'b1;
                sr_q.value <= esr;
                restart_q  <= 1'b1;
            end
            if (do_bank_wr) restart_q <= 1'b1;
            if (rd_go) begin
                rd_q.valid <= 1'b1;
                rd_q.value <= rd_value;
            end
            if (vf_done) begin
                pc_q.valid <= 1'b1;
                pc_q.value <= vf_data;
                restart_q  <= 1'b1;
            end
        end
    end

    assign busy          = active;
    assign pc_bank       = cur_bank;
    assign pc_load_valid = pc_q.valid;
    assign pc_load_value = pc_q.value;
    assign sr_load_valid = sr_q.valid;
    assign sr_load_value = sr_q.value;
    assign fetch_restart = restart_q;
    assign sop_rvalid    = rd_q.valid;
    assign sop_rdata     = rd_q.value;

    AST_EPC_SAVED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> epc == $past(cur_pc) - 16'd2); // R1
    AST_SR_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> sr_load_valid && !sr_load_value[IE0_BIT] && !sr_load_value[IE1_BIT]); // R3
    AST_BANK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> fetch_restart && pc_load_valid && pc_bank == '0); // R5
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> !sr_load_valid && !sop_rvalid && !fetch_restart); // R11
endmodule

// File: tb/sim_exc_sequencer.sv
module sim_exc_sequencer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 1'b0;
    logic [7:0]  exc_num = '0;
    logic [15:0] cur_pc = '0, cur_sr = '0;
    logic        sop_valid = 1'b0;
    logic [3:0]  sop_code = '0;
    logic [15:0] sop_wdata = '0;
    logic        vrd_valid, vrd_ready = 1'b0, vrd_rvalid = 1'b0;
    logic [15:0] vrd_addr, vrd_rdata = '0;
    logic        busy, pc_load_valid, sr_load_valid, fetch_restart, sop_rvalid;
    logic [6:0]  pc_bank;
    logic [15:0] pc_load_value, sr_load_value, sop_rdata;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_sequencer u0 (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_num(exc_num),
        .cur_pc(cur_pc), .cur_sr(cur_sr), .sop_valid(sop_valid),
        .sop_code(sop_code), .sop_wdata(sop_wdata),
        .vrd_valid(vrd_valid), .vrd_addr(vrd_addr), .vrd_ready(vrd_ready),
        .vrd_rvalid(vrd_rvalid), .vrd_rdata(vrd_rdata), .busy(busy),
        .pc_bank(pc_bank), .pc_load_valid(pc_load_valid),
        .pc_load_value(pc_load_value), .sr_load_valid(sr_load_valid),
        .sr_load_value(sr_load_value), .fetch_restart(fetch_restart),
        .sop_rvalid(sop_rvalid), .sop_rdata(sop_rdata)
    );

    typedef struct packed {
        logic [15:0] vbase;
        logic [7:0]  num;
        logic [15:0] pc;
        logic [15:0] sr;
        logic [15:0] bankw;
        logic [15:0] data;
        logic [7:0]  stall;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{16'h0100, 8'h03, 16'h2000, 16'hFFFF, 16'h1234, 16'h4000, 8'd0},
        '{16'hFFF0, 8'h10, 16'h0001, 16'h0003, 16'h7F7F, 16'hBEEF, 8'd2},
        '{16'h8000, 8'hFF, 16'h0000, 16'h1234, 16'hFFFF, 16'h0002, 8'd1},
        '{16'h0000, 8'h00, 16'hFFFE, 16'h8001, 16'h0055, 16'h1111, 8'd3}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(logic [3:0] code, logic [15:0] wd);
        @(negedge clk);
        sop_valid = 1'b1; sop_code = code; sop_wdata = wd;
        @(negedge clk);
        sop_valid = 1'b0;
    endtask

    task automatic enter(logic [7:0] num);
        @(negedge clk);
        exc_req = 1'b1; exc_num = num;
        @(negedge clk);
        exc_req = 1'b0;
    endtask

    task automatic finish_vec(logic [15:0] addr, logic [15:0] data, int stall);
        for (int i = 0; i < stall; i++) begin
            chk("R4 request held", {15'd0, vrd_valid}, 32'd1);
            chk("R4 address stable", vrd_addr, addr);
            @(negedge clk);
        end
        chk("R4 address", vrd_addr, addr);
        vrd_ready = 1'b1;
        @(negedge clk);
        vrd_ready = 1'b0;
        chk("R4 single outstanding", {15'd0, vrd_valid}, 32'd0);
        vrd_rvalid = 1'b1; vrd_rdata = data;
        @(negedge clk);
        vrd_rvalid = 1'b0; vrd_rdata = '0;
        chk("R5 pc load strobe", {15'd0, pc_load_valid}, 32'd1);
        chk("R5 pc load value", pc_load_value, data);
        chk("R5 restart", {15'd0, fetch_restart}, 32'd1);
        chk("R5 bank zero", pc_bank, 0);
        chk("R11 busy cleared", {15'd0, busy}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12 busy", {15'd0, busy}, 0);
        chk("R12 bank", pc_bank, 0);
        chk("R12 vrd_valid", {15'd0, vrd_valid}, 0);
        chk("R12 strobes", {pc_load_valid, sr_load_valid, fetch_restart, sop_rvalid}, 0);
        op(4'd6, 16'h0);
        chk("R12 vector base", sop_rdata, 0);
        op(4'd4, 16'h0);
        chk("R12 saved pc", sop_rdata, 0);

        // table walk
        foreach (ROWS[k]) begin
            automatic row_t r = ROWS[k];
            automatic logic [15:0] addr = r.vbase + {7'd0, r.num, 1'b0};
            automatic logic [15:0] epc = r.pc - 16'd2;
            automatic logic [6:0] cb = r.bankw[6:0];
            op(4'd7, r.vbase);
            chk("R9 write base no read", {15'd0, sop_rvalid}, 0);
            op(4'd6, 16'h0);
            chk("R9 read base", sop_rdata, r.vbase);
            op(4'd3, r.bankw);
            chk("R8 restart", {15'd0, fetch_restart}, 1);
            chk("R8 current bank", pc_bank, cb);
            op(4'd2, 16'h0);
            chk("R7 packed read", sop_rdata, r.bankw & 16'h7F7F);
            cur_pc = r.pc; cur_sr = r.sr;
            enter(r.num);
            chk("R11 busy", {15'd0, busy}, 1);
            chk("R3 sr strobe", {15'd0, sr_load_valid}, 1);
            chk("R3 sr masked", sr_load_value, r.sr & 16'hFFFC);
            finish_vec(addr, r.data, int'(r.stall));
            op(4'd4, 16'h0);
            chk("R1 saved pc", sop_rdata, epc);
            op(4'd2, 16'h0);
            chk("R2 saved bank", sop_rdata, {1'b0, cb, 8'h00});
            cur_pc = 16'h0; cur_sr = 16'h0;
            op(4'd0, 16'h0);
            chk("R6 pc restore", {pc_load_valid, pc_load_value}, {1'b1, epc});
            chk("R2 sr restore", {sr_load_valid, sr_load_value}, {1'b1, r.sr});
            chk("R6 restart", {15'd0, fetch_restart}, 1);
            chk("R6 bank restore", pc_bank, cb);
        end

        // R9 saved PC write then return uses it
        op(4'd5, 16'h1357);
        op(4'd4, 16'h0);
        chk("R9 saved pc write", sop_rdata, 16'h1357);
        op(4'd0, 16'h0);
        chk("R6 return to written pc", pc_load_value, 16'h1357);

        // R11 requests while busy are ignored
        op(4'd7, 16'h0200);
        cur_pc = 16'h0100;
        enter(8'd4);
        @(negedge clk);
        exc_req = 1'b1; exc_num = 8'd9; cur_pc = 16'h5555;
        @(negedge clk);
        exc_req = 1'b0;
        chk("R11 addr kept", vrd_addr, 16'h0208);
        op(4'd7, 16'hAAAA);
        op(4'd6, 16'h0);
        chk("R11 no read while busy", {15'd0, sop_rvalid}, 0);
        finish_vec(16'h0208, 16'h0300, 0);
        op(4'd4, 16'h0);
        chk("R11 saved pc kept", sop_rdata, 16'h00FE);
        op(4'd6, 16'h0);
        chk("R11 base unchanged", sop_rdata, 16'h0200);

        // R11 entry beats simultaneous operation
        @(negedge clk);
        exc_req = 1'b1; exc_num = 8'd1;
        sop_valid = 1'b1; sop_code = 4'd7; sop_wdata = 16'h7777;
        @(negedge clk);
        exc_req = 1'b0; sop_valid = 1'b0;
        chk("R11 entry wins", {15'd0, busy}, 1);
        finish_vec(16'h0202, 16'h0400, 1);
        op(4'd6, 16'h0);
        chk("R11 operation dropped", sop_rdata, 16'h0200);

        // R10 trap and undefined codes
        cur_sr = 16'h00FF;
        op(4'd1, 16'h0005);
        chk("R10 trap enters", {15'd0, busy}, 1);
        chk("R10 trap sr masked", sr_load_value, 16'h00FC);
        finish_vec(16'h020A, 16'h0500, 0);
        op(4'd9, 16'h0033);
        chk("R10 undefined enters", {15'd0, busy}, 1);
        finish_vec(16'h0202, 16'h0600, 0);
        op(4'd15, 16'h0);
        finish_vec(16'h0202, 16'h0700, 2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule